// File: doc/BRIEF.md
# Centre-Aligned Boost Gate Modulator with Average-Current Sample Strobe

This block drives the single power switch of a boost rectifier. A free-running counter sets out a switching period that is a fixed power-of-two number of clock cycles. The switch conducts at both ends of each period and is open in its middle. The conduction time is therefore split into two equal halves placed around the period boundary.

Because the conduction interval is centred on count 0, the inductor current at that instant equals its average over the cycle. The block asserts an active-low conversion strobe whose falling edge lands on count 0. One converter sample per period then gives the cycle-average current, and no accumulation is needed. The controller supplies a duty word. The block takes that word once per period, at the period boundary, and limits it so that some off-time always remains.

Top module: `tri_pwm_gen`

## Requirements
- R1: `period_start` is high for exactly one clock cycle at count 0 of every period. A period is 2^PERIOD_W clocks (2048 by default), so the pulses are exactly 2048 cycles apart.
- R2: With an effective duty D and h = floor(D/2), `gate` is high on counts 0..h-1 and on counts 2048-h..2047, and low on all other counts.
- R3: `duty` is sampled only at the clock edge that moves the counter from 2047 to 0, which is the edge that raises `period_start`. A change of `duty` at any other time does not alter `gate` in the current period.
- R4: A duty word of 0 or 1 keeps `gate` low for the entire period.
- R5: A duty word above 2048-MIN_OFF (1984 by default) is used as 1984. `gate` is then low for at least 64 counts, and those counts are centred on count 1024.
- R6: `conv_n` is low on counts 0..STROBE_LEN-1 (0..7 by default) and high on all other counts. Its falling edge coincides with `period_start`.
- R7: While `rst_n` is low, `gate` is 0, `conv_n` is 1 and `period_start` is 0. Reset takes effect asynchronously.
- R8: After `rst_n` is released, the first rising clock edge starts a period at count 0 with the duty word present at that edge. `period_start` is high in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty | input | PERIOD_W | Requested on-time in counts, taken at the period boundary |
| gate | output | 1 | Switch drive, high means conducting |
| conv_n | output | 1 | Active-low converter strobe, falls at count 0 |
| period_start | output | 1 | One-cycle pulse at count 0 |

## Verification
Directed duty words cover the extremes. Values 0 and 1 must both give an all-off period, and 2 gives the narrowest on-pulse, which together expose errors in the halving step. Values 1984, 1985 and 2047 separate correct clamping from wrap-around, and the odd/even pair 1000/1001 confirms that halving truncates. Random duty words follow, each with a random change to `duty` driven in the middle of the period, and every cycle of the gate is compared against a model of the word that should have been latched. A reset applied while the gate is on, followed by release, checks that the outputs go idle and that the counter restarts cleanly.

// File: rtl/tri_pwm_gen.sv
module tri_pwm_gen #(
  parameter int PERIOD_W   = 11,
  parameter int MIN_OFF    = 64,
  parameter int STROBE_LEN = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] duty,
  output logic                gate,
  output logic                conv_n,
  output logic                period_start
);

  localparam int                PERIOD = 1 << PERIOD_W;
  localparam logic [PERIOD_W:0]   PER_X  = PERIOD[PERIOD_W:0];
  localparam logic [PERIOD_W-1:0] LAST   = PERIOD_W'(PERIOD - 1);
  localparam logic [PERIOD_W-1:0] DMAX   = PERIOD_W'(PERIOD - MIN_OFF);
  localparam logic [PERIOD_W-1:0] SLEN   = PERIOD_W'(STROBE_LEN);
  localparam logic [PERIOD_W-1:0] MID    = PERIOD_W'(PERIOD / 2);

  logic                run;
  logic [PERIOD_W-1:0] cnt;
  logic [PERIOD_W-1:0] duty_act;
  logic [PERIOD_W-1:0] half;
  logic                load;

  assign load = !run || (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      cnt      <= '0;
      duty_act <= '0;
    end else begin
      run <= 1'b1;
      if (run) cnt <= cnt + 1'b1;
      if (load) duty_act <= (duty > DMAX) ? DMAX : duty;
    end
  end

  assign half         = duty_act >> 1;
  assign gate         = run && ((cnt < half) || ({1'b0, cnt} >= (PER_X - {1'b0, half})));
  assign conv_n       = !(run && (cnt < SLEN));
  assign period_start = run && (cnt == '0);

  assert_pulse_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> !period_start);
  assert_period_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == LAST) |=> period_start);
  assert_on_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && duty_act >= 2) |-> gate);
  assert_duty_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != LAST) |=> $stable(duty_act));
  assert_zero_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && duty_act < 2) |-> !gate);
  assert_mid_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == MID) |-> !gate);
  assert_strobe_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_n) |-> period_start);

  always_ff @(posedge clk) begin
    if (!rst_n) assert_reset_idle_R7: assert (!gate && conv_n && !period_start);
  end

endmodule

// File: tb/test_tri_pwm_gen.sv
module test_tri_pwm_gen;

  localparam int PW   = 11;
  localparam int PER  = 1 << PW;
  localparam int MOFF = 64;
  localparam int SLEN = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] duty = '0;
  logic          gate, conv_n, period_start;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int cur_d;

  tri_pwm_gen #(.PERIOD_W(PW), .MIN_OFF(MOFF), .STROBE_LEN(SLEN)) i_tri_pwm_gen (
    .clk(clk), .rst_n(rst_n), .duty(duty),
    .gate(gate), .conv_n(conv_n), .period_start(period_start)
  );

  always #5 clk = ~clk;

  function automatic bit exp_gate(int d, int k);
    int e = (d > PER - MOFF) ? PER - MOFF : d;
    int h = e / 2;
    return (k < h) || (k >= PER - h);
  endfunction

  function automatic bit exp_conv(int k);
    return !(k < SLEN);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_period(int d_next, bit junk, string req);
    int g_bad = 0, c_bad = 0, p_bad = 0;
    for (int k = 0; k < PER; k++) begin
      if (gate !== exp_gate(cur_d, k)) g_bad++;
      if (conv_n !== exp_conv(k)) c_bad++;
      if (period_start !== (k == 0)) p_bad++;
      if (junk && k == 700) duty = PW'($urandom);
      if (k == PER - 1) duty = PW'(d_next);
      @(negedge clk);
    end
    chk(g_bad == 0, req, g_bad, 0);
    chk(c_bad == 0, "R6 strobe window", c_bad, 0);
    chk(p_bad == 0, "R1 period pulse", p_bad, 0);
    cur_d = d_next;
  endtask

  initial begin
    int dir [8] = '{0, 1, 2, 1984, 1985, 2047, 1000, 1001};
    string tag [8] = '{"R4 duty 0", "R4 duty 1", "R2 duty 2", "R5 duty 1984",
                       "R5 duty 1985", "R5 duty 2047", "R2 duty 1000", "R2 duty 1001"};
    void'($urandom(32'd1357));
    duty = 11'd600;
    repeat (3) @(negedge clk);
    chk(gate == 1'b0, "R7 gate in reset", gate, 0);
    chk(conv_n == 1'b1, "R7 conv_n in reset", conv_n, 1);
    chk(period_start == 1'b0, "R7 period_start in reset", period_start, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(period_start == 1'b1, "R8 first period", period_start, 1);
    cur_d = 600;
    for (int i = 0; i < 8; i++) begin
      duty = PW'(dir[i]);
      run_period(dir[i], 1'b0, "R2 gate shape");
      run_period((i < 7) ? dir[i+1] : 1000, 1'b0, tag[i]);
    end
    for (int i = 0; i < 6; i++) begin
      run_period(int'($urandom_range(0, PER - 1)), 1'b1, "R3 mid-period duty change");
    end
    run_period(1000, 1'b1, "R3 mid-period duty change");
    @(negedge clk);
    @(negedge clk);
    chk(gate == 1'b1, "R2 gate on near start", gate, 1);
    rst_n = 1'b0;
    #1;
    chk(gate == 1'b0, "R7 gate async reset", gate, 0);
    chk(conv_n == 1'b1, "R7 conv_n async reset", conv_n, 1);
    chk(period_start == 1'b0, "R7 period_start async reset", period_start, 0);
    @(negedge clk);
    duty = 11'd400;
    rst_n = 1'b1;
    @(negedge clk);
    chk(period_start == 1'b1, "R8 restart", period_start, 1);
    cur_d = 400;
    run_period(400, 1'b0, "R8 first period shape");
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule